// File: doc/BRIEF.md
# Unconditional Transfer Next-PC Unit

This block sits beside the fetch stage of a 32-bit load/store core with fixed-width 4-byte instructions. It chooses the address of the next instruction and, for call-type transfers, produces the register write that saves the return address. It takes four inputs: the current program counter, the fetched instruction word, and the two source register values that an external register file has already read for the instruction.

Four unconditional transfers are recognised. Each has its own target source and its own link rule.
- **Region jump:** the target comes from a 26-bit word index inside the current 256 MiB region.
- **Region call:** the same target as the region jump, plus a link write.
- **Register jump:** the target is the first source register.
- **Register call:** the target is the second source register, plus a link write.

Every other instruction falls through to the next sequential word. The block is purely combinational, so all outputs follow the inputs within the same cycle.

Top module: `jl_next_pc`

## Requirements
- R1: When the opcode (instr bits 31:26) is any value other than 0, 2 or 3, next_pc equals pc+4 and link_we is 0.
- R2: Opcode 2 gives next_pc = {bits 31:28 of pc+4, instr[25:0], 2'b00}, and link_we is 0.
- R3: Opcode 3 gives the same next_pc as opcode 2, and link_we is 1.
- R4: Opcode 0 with function code 8 (instr bits 5:0) gives next_pc = rs_val, and link_we is 0.
- R5: Opcode 0 with function code 9 gives next_pc = rt_val, and link_we is 1.
- R6: While link_we is 1, link_idx is 31 and link_val is pc+4. While link_we is 0, link_idx and link_val are both 0.
- R7: Opcode 0 with any function code other than 8 or 9 gives next_pc = pc+4 and link_we = 0. Neither rs_val nor rt_val reaches next_pc in this case.
- R8: pc+4 wraps modulo 2^32. The region bits of a jump target come from the wrapped pc+4, not from pc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Fetched instruction word |
| rs_val | input | 32 | Value read from the first source register |
| rt_val | input | 32 | Value read from the second source register |
| next_pc | output | 32 | Address of the next instruction to fetch |
| link_we | output | 1 | Return-address register write enable |
| link_idx | output | 5 | Destination register index of the link write |
| link_val | output | 32 | Return address to be written |

## Verification
The block holds no state, so a wrong internal decode shows at the ports in the same cycle the instruction is presented. A misclassified transfer appears either as a next_pc taken from the wrong source or as a link write that is raised or dropped when it should not be.

The directed scenarios give each source a distinct value (rs_val, rt_val, the index field and pc+4). A wrong selection therefore differs in value and cannot be masked. The wrap scenarios separately expose a region taken from pc instead of pc+4.

// File: rtl/jl_pkg.sv
package jl_pkg;
    parameter int XLEN        = 32;
    parameter int OPC_W       = 6;
    parameter int FN_W        = 6;
    parameter int IDX_W       = 26;
    parameter int RIDX_W      = 5;
    parameter int INSTR_BYTES = 4;
    parameter int LINK_REG    = 31;
    parameter int OPC_SPECIAL = 0;
    parameter int OPC_JUMP    = 2;
    parameter int OPC_CALL    = 3;
    parameter int FN_RJUMP    = 8;
    parameter int FN_RCALL    = 9;

    localparam int ALIGN_W  = $clog2(INSTR_BYTES);
    localparam int REGION_W = XLEN - IDX_W - ALIGN_W;

    typedef enum logic [2:0] {
        XF_SEQ   = 3'd0,
        XF_JUMP  = 3'd1,
        XF_CALL  = 3'd2,
        XF_RJUMP = 3'd3,
        XF_RCALL = 3'd4
    } xfer_e;

    typedef struct packed {
        xfer_e              kind;
        logic [IDX_W-1:0]   idx;
    } dec_t;

    function automatic logic [XLEN-1:0] region_target(
        input logic [XLEN-1:0]  seq,
        input logic [IDX_W-1:0] idx
    );
        return {seq[XLEN-1 -: REGION_W], idx, {ALIGN_W{1'b0}}};
    endfunction

    function automatic logic is_link(input xfer_e k);
        return (k == XF_CALL) || (k == XF_RCALL);
    endfunction
endpackage

// File: rtl/jl_decode.sv
module jl_decode
    import jl_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;

    assign opc = instr[XLEN-1 -: OPC_W];
    assign fn  = instr[FN_W-1:0];

    always_comb begin
        dec.idx  = instr[IDX_W-1:0];
        dec.kind = XF_SEQ;
        if (opc == OPC_W'(OPC_JUMP)) begin
            dec.kind = XF_JUMP;
        end else if (opc == OPC_W'(OPC_CALL)) begin
            dec.kind = XF_CALL;
        end else if (opc == OPC_W'(OPC_SPECIAL)) begin
            if (fn == FN_W'(FN_RJUMP))      dec.kind = XF_RJUMP;
            else if (fn == FN_W'(FN_RCALL)) dec.kind = XF_RCALL;
        end
    end

    // R7: register forms only come from the special opcode
    always_comb begin
        p_reg_forms_special_r7: assert (!((dec.kind == XF_RJUMP || dec.kind == XF_RCALL)
                                          && opc != OPC_W'(OPC_SPECIAL)))
            else $error("register transfer decoded from non-special opcode");
    end
endmodule

// File: rtl/jl_target.sv
module jl_target
    import jl_pkg::*;
(
    input  dec_t            dec,
    input  logic [XLEN-1:0] seq_pc,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] next_pc
);
    always_comb begin
        unique case (dec.kind)
            XF_JUMP, XF_CALL: next_pc = region_target(seq_pc, dec.idx);
            XF_RJUMP:         next_pc = rs_val;
            XF_RCALL:         next_pc = rt_val;
            default:          next_pc = seq_pc;
        endcase
    end

    // R2 / R8: a region target stays word aligned inside the region of pc+4
    always_comb begin
        p_region_kept_r2: assert (!(dec.kind == XF_JUMP || dec.kind == XF_CALL)
                                  || (next_pc[XLEN-1 -: REGION_W] == seq_pc[XLEN-1 -: REGION_W]
                                      && next_pc[ALIGN_W-1:0] == '0))
            else $error("region target left the region or lost alignment");
    end
endmodule

// File: rtl/jl_link.sv
module jl_link
    import jl_pkg::*;
(
    input  xfer_e             kind,
    input  logic [XLEN-1:0]   seq_pc,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_val
);
    always_comb begin
        link_we  = is_link(kind);
        link_idx = link_we ? RIDX_W'(LINK_REG) : '0;
        link_val = link_we ? seq_pc : '0;
    end
endmodule

// File: rtl/jl_next_pc.sv
module jl_next_pc
    import jl_pkg::*;
(
    input  logic [31:0] pc,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] next_pc,
    output logic        link_we,
    output logic [4:0]  link_idx,
    output logic [31:0] link_val
);
    logic [XLEN-1:0] seq_pc;
    dec_t            dec;

    assign seq_pc = pc + XLEN'(INSTR_BYTES);

    jl_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    jl_target u_tgt (
        .dec     (dec),
        .seq_pc  (seq_pc),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .next_pc (next_pc)
    );

    jl_link u_lnk (
        .kind     (dec.kind),
        .seq_pc   (seq_pc),
        .link_we  (link_we),
        .link_idx (link_idx),
        .link_val (link_val)
    );

    always_comb begin
        // R1: plain fall-through goes to the next word
        p_seq_step_r1: assert (dec.kind != XF_SEQ || next_pc == seq_pc)
            else $error("fall-through not at pc+4");
        // R3: the region call opcode always raises the link write
        p_call_links_r3: assert (instr[31:26] != 6'd3 || link_we)
            else $error("region call without link write");
        // R6: a link write always targets the return register with pc+4
        p_link_dest_r6: assert (!link_we || (link_idx == 5'd31 && link_val == seq_pc))
            else $error("link write has wrong destination or value");
        // R6: no stray link fields when nothing is written
        p_link_quiet_r6: assert (link_we || (link_idx == '0 && link_val == '0))
            else $error("link fields active without write");
    end
endmodule

// File: tb/sim_jl_next_pc.sv
module sim_jl_next_pc;
    logic        clk = 1'b0;
    logic [31:0] pc = '0, instr = '0, rs_val = '0, rt_val = '0;
    logic [31:0] next_pc, link_val;
    logic        link_we;
    logic [4:0]  link_idx;
    int          n_run = 0, n_fail = 0, cycles = 0;

    always #2.5 clk = ~clk;

    jl_next_pc u0 (
        .pc(pc), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .next_pc(next_pc), .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] p, input logic [31:0] i,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        pc = p; instr = i; rs_val = a; rt_val = b;
        #1;
    endtask

    task automatic chk_nolink(input string req);
        chk(req, {31'd0, link_we}, 32'd0);
        chk(req, {27'd0, link_idx}, 32'd0);
        chk(req, link_val, 32'd0);
    endtask

    task automatic t_idle;
        #1;
        chk("R1 idle", next_pc, 32'h4);
        chk_nolink("R6 idle");
    endtask

    task automatic t_seq;
        apply(32'h0000_1000, {6'd35, 26'h155_5555}, 32'hAAAA_0000, 32'hBBBB_0000);
        chk("R1 load opcode", next_pc, 32'h0000_1004);
        chk_nolink("R1 load opcode");
        apply(32'h8000_0010, {6'd4, 26'h3FF_FFFF}, 32'h1111_1110, 32'h2222_2220);
        chk("R1 branch opcode", next_pc, 32'h8000_0014);
        chk_nolink("R1 branch opcode");
    endtask

    task automatic t_jump;
        apply(32'h4000_1000, {6'd2, 26'h012_3456}, 32'hDEAD_0000, 32'hBEEF_0000);
        chk("R2 region jump", next_pc, 32'h4048_D158);
        chk_nolink("R2 region jump");
    endtask

    task automatic t_call;
        apply(32'h4000_1000, {6'd3, 26'h012_3456}, 32'hDEAD_0000, 32'hBEEF_0000);
        chk("R3 region call", next_pc, 32'h4048_D158);
        chk("R3 link_we", {31'd0, link_we}, 32'd1);
        chk("R6 call idx", {27'd0, link_idx}, 32'd31);
        chk("R6 call val", link_val, 32'h4000_1004);
    endtask

    task automatic t_rjump;
        apply(32'h0000_2000, {6'd0, 5'd31, 15'd0, 6'd8}, 32'h0000_3ABC, 32'h0000_7770);
        chk("R4 register jump", next_pc, 32'h0000_3ABC);
        chk_nolink("R4 register jump");
    endtask

    task automatic t_rcall;
        apply(32'h0000_2000, {6'd0, 5'd4, 5'd5, 10'd0, 6'd9}, 32'h0000_3ABC, 32'h0000_7770);
        chk("R5 register call", next_pc, 32'h0000_7770);
        chk("R5 link_we", {31'd0, link_we}, 32'd1);
        chk("R6 rcall idx", {27'd0, link_idx}, 32'd31);
        chk("R6 rcall val", link_val, 32'h0000_2004);
    endtask

    task automatic t_special_other;
        apply(32'h0000_0100, {6'd0, 20'h12345, 6'd32}, 32'h5555_5550, 32'h6666_6660);
        chk("R7 special add", next_pc, 32'h0000_0104);
        chk_nolink("R7 special add");
        apply(32'h0000_0100, {6'd0, 20'h0, 6'd10}, 32'h5555_5550, 32'h6666_6660);
        chk("R7 special fn10", next_pc, 32'h0000_0104);
        chk_nolink("R7 special fn10");
    endtask

    task automatic t_wrap;
        apply(32'hFFFF_FFFC, 32'h8C00_0000, 32'h1, 32'h2);
        chk("R8 seq wrap", next_pc, 32'h0000_0000);
        apply(32'h0FFF_FFFC, {6'd2, 26'h3FF_FFFF}, 32'h1, 32'h2);
        chk("R8 region from pc+4", next_pc, 32'h1FFF_FFFC);
        apply(32'hFFFF_FFFC, {6'd3, 26'h000_0001}, 32'h1, 32'h2);
        chk("R8 call wrap target", next_pc, 32'h0000_0004);
        chk("R8 call wrap link", link_val, 32'h0000_0000);
        chk("R8 call wrap we", {31'd0, link_we}, 32'd1);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected <= 5000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_seq();
        t_jump();
        t_call();
        t_rjump();
        t_rcall();
        t_special_other();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule